// File: doc/BRIEF.md
# Register-Tile Signed Byte Matrix Multiplier

This block multiplies a 2-row left tile by an N-column right tile and produces a 2×N grid of signed 32-bit sums. Both operand tiles arrive whole, as packed words the size of a vector register group. The tile geometry follows the register shape. The output always has two rows. N is VLEN/64. The reduction depth K scales with the run-time register-group multiplier and with the element width by the rule K = VLEN·LMUL/(2·SEW). This instance handles signed 8-bit inputs, so at VLEN=128 K is 8, 16, 32 or 64.

A caller presents the operands, a multiplier code and an accumulate flag together with a start strobe while ready is high. The engine captures everything in that cycle. It runs 2·N multiply-accumulate lanes in parallel and steps through one k per cycle. It pulses done one cycle after the last k, and the packed result is valid in that same cycle. With the accumulate flag set, the new products are added to the sums already held. With the flag clear, those sums are replaced. A multiplier code that is not a whole power of two is refused with a one-cycle error pulse.

Top module: `tmm_top`

## Requirements
- R1: After reset, ready is 1, done is 0, err is 0 and every result lane is 0.
- R2: grpCode values 0, 1, 2 and 3 select group multipliers 1, 2, 4 and 8, and K = VLEN·mult/(2·SEW). If start is accepted in cycle 0, busy cycles 1..K follow with done low, and done is high in cycle K+1.
- R3: ready is low from the cycle after an accepted start until done rises. Ready is high again in the done cycle.
- R4: Left element (r,k) is read from leftTile bits [8·(r·K+k) +: 8], with r in 0..1.
- R5: Right element (k,n) is read from rightTile bits [8·(n·K+k) +: 8].
- R6: Result lane (r,n) sits at result bits [32·(r·N+n) +: 32]. It holds the sum over k of left(r,k)·right(k,n), taken modulo 2^32.
- R7: When accEn=1 at start, the new sum is added to the lane's previous value. When accEn=0, the lane is overwritten. Between operations the result holds.
- R8: Operands are signed two's-complement bytes, and each product is sign-extended before it is summed. This includes −128.
- R9: A start with grpCode 4..7 (the fractional or reserved codes) raises err for exactly the next cycle. It does not raise done, does not drop ready and leaves the result unchanged.
- R10: A start raised while ready is low is ignored. The running operation finishes with its own result and only one done pulse.
- R11: The operands, grpCode and accEn are sampled only in the start cycle. Changing them afterwards has no effect on the result.
- R12: A start in the cycle that done is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; taken when ready is high |
| ready | output | 1 | Engine idle and able to accept start |
| grpCode | input | 3 | Register-group multiplier code; 0..3 are legal |
| accEn | input | 1 | Add to the held result instead of overwriting it |
| leftTile | input | 2·KMAX·SEW (1024) | Left 2×K tile, row-major |
| rightTile | input | KMAX·N·SEW (1024) | Right K×N tile, column-major |
| result | output | 2·N·32 (128) | Packed 2×N signed sums, row-major |
| done | output | 1 | One-cycle pulse when the result is complete |
| err | output | 1 | One-cycle pulse for a refused start |

## Verification
The completion pulse and the acceptance of the next operation can happen in the same cycle. This is how accumulating tiles are chained without a gap. The bench raises a new start with the accumulate flag in the very cycle it sees done. It then checks that the second result equals the first sum plus the freshly computed products, and that the busy window begins at once. A start raised in the middle of a run is also provoked, and the bench confirms that only the first operation's result and a single done appear. Every group multiplier is swept with random, all-minimum and alternating-extreme byte patterns.

// File: rtl/tmm_pkg.sv
package tmm_pkg;

  // Strobes from the sequencer to the arithmetic lanes
  typedef struct packed {
    logic latchOps;   // capture operand tiles
    logic clearAcc;   // zero the lane sums before a fresh run
    logic macEn;      // add one product per lane this cycle
  } tmmStrobe_t;

  // Map the register-group code to a whole multiplier; 0 flags a refused code
  function automatic int unsigned grpFactor(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 8;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tmm_ctrl.sv
module tmm_ctrl
  import tmm_pkg::*;
#(
  parameter int VLEN    = 128,
  parameter int SEW     = 8,
  parameter int MAXLMUL = 8,
  parameter int KMAX    = 64,
  parameter int KW      = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [2:0]    grpCode,
  input  logic          accEn,
  output logic          ready,
  output logic          done,
  output logic          err,
  output tmmStrobe_t    stb,
  output logic [KW-1:0] kIdx,
  output logic [KW-1:0] kLen
);

  localparam int KBASE = VLEN / (2 * SEW);

  typedef enum logic {IDLE, RUN} tmmState_e;

  tmmState_e     state;
  logic [KW-1:0] kIdxQ;
  logic [KW-1:0] kLenQ;
  logic          doneQ;
  logic          errQ;

  int unsigned   factor;
  logic          legal;
  logic [KW-1:0] kCalc;
  logic          idle;
  logic          accept;
  logic          lastK;

  always_comb begin
    factor = grpFactor(grpCode);
    legal  = (factor != 0) && (factor <= MAXLMUL);
    kCalc  = KW'(KBASE * factor);
    idle   = (state == IDLE);
    accept = start && idle && legal;
    lastK  = (kIdxQ == KW'(kLenQ - 1'b1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
      kIdxQ <= '0;
      kLenQ <= '0;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      errQ  <= start && idle && !legal;
      case (state)
        IDLE: begin
          if (accept) begin
            state <= RUN;
            kIdxQ <= '0;
            kLenQ <= kCalc;
          end
        end
        RUN: begin
          if (lastK) begin
            state <= IDLE;
            doneQ <= 1'b1;
          end else begin
            kIdxQ <= kIdxQ + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_comb begin
    stb.latchOps = accept;
    stb.clearAcc = accept && !accEn;
    stb.macEn    = (state == RUN);
  end

  assign ready = idle;
  assign done  = doneQ;
  assign err   = errQ;
  assign kIdx  = kIdxQ;
  assign kLen  = kLenQ;

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !ready);

  // R3
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> $past(state == RUN));

  // R2
  kidx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == RUN) |-> (kIdxQ < kLenQ));

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> (idle && !doneQ));

endmodule

// File: rtl/tmm_dp.sv
module tmm_dp
  import tmm_pkg::*;
#(
  parameter int SEW  = 8,
  parameter int ACCW = 32,
  parameter int NCOL = 2,
  parameter int KMAX = 64,
  parameter int KW   = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  tmmStrobe_t                  stb,
  input  logic [KW-1:0]               kIdx,
  input  logic [KW-1:0]               kLen,
  input  logic [2*KMAX*SEW-1:0]       leftIn,
  input  logic [KMAX*NCOL*SEW-1:0]    rightIn,
  output logic [2*NCOL*ACCW-1:0]      accFlat
);

  localparam int LW    = 2 * KMAX * SEW;
  localparam int RW    = KMAX * NCOL * SEW;
  localparam int LIW   = $clog2(LW);
  localparam int RIW   = $clog2(RW);
  localparam int PW    = 2 * SEW;
  localparam int LANES = 2 * NCOL;

  logic [LW-1:0] leftQ;
  logic [RW-1:0] rightQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftQ  <= '0;
      rightQ <= '0;
    end else if (stb.latchOps) begin
      leftQ  <= leftIn;
      rightQ <= rightIn;
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    localparam int ROW = lane / NCOL;
    localparam int COL = lane % NCOL;

    logic [LIW-1:0]        aPos;
    logic [RIW-1:0]        bPos;
    logic signed [SEW-1:0] aVal;
    logic signed [SEW-1:0] bVal;
    logic signed [PW-1:0]  prod;
    logic [ACCW-1:0]       prodExt;
    logic [ACCW-1:0]       sumQ;

    always_comb begin
      aPos    = LIW'(SEW * (ROW * int'(kLen) + int'(kIdx)));
      bPos    = RIW'(SEW * (COL * int'(kLen) + int'(kIdx)));
      aVal    = leftQ[aPos +: SEW];
      bVal    = rightQ[bPos +: SEW];
      prod    = aVal * bVal;
      prodExt = {{(ACCW-PW){prod[PW-1]}}, prod};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        sumQ <= '0;
      else if (stb.clearAcc)
        sumQ <= '0;
      else if (stb.macEn)
        sumQ <= sumQ + prodExt;
    end

    assign accFlat[lane*ACCW +: ACCW] = sumQ;
  end

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.macEn && !stb.clearAcc) |=> $stable(accFlat));

  // R6
  k_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.macEn && $past(stb.macEn)) |-> (kIdx == KW'($past(kIdx) + 1'b1)));

endmodule

// File: rtl/tmm_top.sv
module tmm_top
  import tmm_pkg::*;
#(
  parameter int VLEN    = 128,
  parameter int SEW     = 8,
  parameter int ACCW    = 32,
  parameter int MAXLMUL = 8,
  localparam int NCOL   = VLEN / 64,
  localparam int KMAX   = VLEN * MAXLMUL / (2 * SEW),
  localparam int LW     = 2 * KMAX * SEW,
  localparam int RW     = KMAX * NCOL * SEW,
  localparam int RESW   = 2 * NCOL * ACCW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  output logic            ready,
  input  logic [2:0]      grpCode,
  input  logic            accEn,
  input  logic [LW-1:0]   leftTile,
  input  logic [RW-1:0]   rightTile,
  output logic [RESW-1:0] result,
  output logic            done,
  output logic            err
);

  localparam int KW = $clog2(KMAX + 1);

  tmmStrobe_t    stb;
  logic [KW-1:0] kIdx;
  logic [KW-1:0] kLen;

  tmm_ctrl #(
    .VLEN(VLEN), .SEW(SEW), .MAXLMUL(MAXLMUL), .KMAX(KMAX), .KW(KW)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .grpCode(grpCode), .accEn(accEn),
    .ready(ready), .done(done), .err(err), .stb(stb), .kIdx(kIdx), .kLen(kLen)
  );

  tmm_dp #(
    .SEW(SEW), .ACCW(ACCW), .NCOL(NCOL), .KMAX(KMAX), .KW(KW)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .kIdx(kIdx), .kLen(kLen),
    .leftIn(leftTile), .rightIn(rightTile), .accFlat(result)
  );

endmodule

// File: tb/tb_tmm_top.sv
module tb_tmm_top;

  localparam int CLK_PERIOD = 10;
  localparam int VLEN    = 128;
  localparam int SEW     = 8;
  localparam int ACCW    = 32;
  localparam int MAXLMUL = 8;
  localparam int NCOL    = VLEN / 64;
  localparam int KMAX    = VLEN * MAXLMUL / (2 * SEW);
  localparam int LW      = 2 * KMAX * SEW;
  localparam int RW      = KMAX * NCOL * SEW;
  localparam int RESW    = 2 * NCOL * ACCW;

  logic            clk = 1'b0;
  logic            rstN;
  logic            start;
  logic            ready;
  logic [2:0]      grpCode;
  logic            accEn;
  logic [LW-1:0]   leftTile;
  logic [RW-1:0]   rightTile;
  logic [RESW-1:0] result;
  logic            done;
  logic            err;

  tmm_top #(.VLEN(VLEN), .SEW(SEW), .ACCW(ACCW), .MAXLMUL(MAXLMUL)) dut (
    .clk(clk), .rstN(rstN), .start(start), .ready(ready), .grpCode(grpCode),
    .accEn(accEn), .leftTile(leftTile), .rightTile(rightTile),
    .result(result), .done(done), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  nChecks = 0;
  int  nFails  = 0;
  byte aM [2][KMAX];
  byte bM [KMAX][NCOL];
  int  expR [2][NCOL];

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  function automatic byte pick(input int mode, input int i, input int j);
    case (mode)
      1:       return -8'sd128;
      2:       return ((i + j) % 2 == 0) ? 8'sd127 : -8'sd128;
      3:       return byte'(i * 3 - j * 5 - 7);
      default: return byte'($urandom);
    endcase
  endfunction

  task automatic fillOps(input int mode, input int kk);
    for (int i = 0; i < LW / 32; i++) leftTile[i*32 +: 32] = $urandom;
    for (int i = 0; i < RW / 32; i++) rightTile[i*32 +: 32] = $urandom;
    for (int r = 0; r < 2; r++)
      for (int k = 0; k < kk; k++) begin
        aM[r][k] = pick(mode, r, k);
        leftTile[8*(r*kk+k) +: 8] = aM[r][k];
      end
    for (int k = 0; k < kk; k++)
      for (int n = 0; n < NCOL; n++) begin
        bM[k][n] = pick(mode, k + 1, n);
        rightTile[8*(n*kk+k) +: 8] = bM[k][n];
      end
  endtask

  task automatic computeExp(input int kk, input bit acc);
    for (int r = 0; r < 2; r++)
      for (int n = 0; n < NCOL; n++) begin
        int s;
        s = acc ? expR[r][n] : 0;
        for (int k = 0; k < kk; k++) s += int'(aM[r][k]) * int'(bM[k][n]);
        expR[r][n] = s;
      end
  endtask

  task automatic checkResult(input string tag);
    for (int r = 0; r < 2; r++)
      for (int n = 0; n < NCOL; n++)
        chk(tag, longint'($signed(result[32*(r*NCOL+n) +: 32])), longint'(expR[r][n]));
  endtask

  // Called at a negedge; start is seen at the following posedge (cycle 0)
  task automatic startOp(input logic [2:0] code, input bit acc);
    grpCode = code;
    accEn   = acc;
    start   = 1'b1;
    chk("R3 ready before start", ready, 1);
    @(negedge clk);
    start = 1'b0;
    // R11: scramble all sampled inputs after the start cycle
    for (int i = 0; i < LW / 32; i++) leftTile[i*32 +: 32] = $urandom;
    for (int i = 0; i < RW / 32; i++) rightTile[i*32 +: 32] = $urandom;
    accEn   = ~acc;
    grpCode = 3'($urandom);
  endtask

  task automatic waitDone(input int kk, input bit disturb);
    for (int j = 0; j < kk; j++) begin
      chk("R3 ready low while busy", ready, 0);
      chk("R2 no early done", done, 0);
      if (disturb && j == 1) start = 1'b1;  // R10
      @(negedge clk);
      if (disturb && j == 1) start = 1'b0;
    end
    chk("R2 done at cycle K+1", done, 1);
    chk("R3 ready with done", ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; grpCode = '0; accEn = 1'b0;
    leftTile = '0; rightTile = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready", ready, 1);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    for (int r = 0; r < 2; r++) for (int n = 0; n < NCOL; n++) expR[r][n] = 0;
    checkResult("R1 result zero");

    // Sweep every multiplier and pattern (R2 R4 R5 R6 R8 R11)
    for (int code = 0; code < 4; code++) begin
      int kk;
      kk = (VLEN / (2 * SEW)) << code;
      for (int mode = 0; mode < 4; mode++) begin
        fillOps(mode, kk);
        computeExp(kk, 1'b0);
        startOp(3'(code), 1'b0);
        waitDone(kk, 1'b0);
        checkResult((mode == 1 || mode == 2) ? "R8 signed extremes" : "R4 R5 R6 R11 product");
        @(negedge clk);
        chk("R2 done one cycle", done, 0);
      end
      // R7 accumulate on top of the previous sum
      fillOps(0, kk);
      computeExp(kk, 1'b1);
      startOp(3'(code), 1'b1);
      waitDone(kk, 1'b0);
      checkResult("R7 accumulate");
    end

    // R9 refused codes
    for (int code = 4; code < 8; code++) begin
      @(negedge clk);
      grpCode = 3'(code);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9 err pulse", err, 1);
      chk("R9 ready kept", ready, 1);
      chk("R9 no done", done, 0);
      @(negedge clk);
      chk("R9 err one cycle", err, 0);
      chk("R9 no done later", done, 0);
      checkResult("R9 result unchanged");
    end

    // R7 overwrite after accumulation
    @(negedge clk);
    fillOps(3, 16);
    computeExp(16, 1'b0);
    startOp(3'd1, 1'b0);
    waitDone(16, 1'b0);
    checkResult("R7 overwrite");

    // R10 start while busy is ignored
    @(negedge clk);
    fillOps(0, 32);
    computeExp(32, 1'b0);
    startOp(3'd2, 1'b0);
    waitDone(32, 1'b1);
    checkResult("R10 busy start ignored");
    @(negedge clk);
    chk("R10 single done", done, 0);
    chk("R10 still idle", ready, 1);
    repeat (3) begin
      @(negedge clk);
      chk("R10 no second run", ready, 1);
    end

    // R12 back-to-back with accumulate, started in the done cycle
    fillOps(0, 8);
    computeExp(8, 1'b0);
    startOp(3'd0, 1'b0);
    waitDone(8, 1'b0);
    checkResult("R12 first of pair");
    fillOps(2, 64);
    computeExp(64, 1'b1);
    startOp(3'd3, 1'b1);
    waitDone(64, 1'b0);
    checkResult("R12 chained accumulate");

    @(negedge clk);
    summary();
    $finish;
  end

endmodule